// File: doc/BRIEF.md
# Incrementing-Burst Bus Master with Error Abort

This block turns a single burst command into a run of single-word AHB-Lite transfers. The command carries a base address, a beat count and a direction. The block drives the address phase of each beat and takes part in the data phase one cycle later. Write words come from a valid/ready stream and are consumed in beat order. Read words leave on a strobe. The strobe has no ready, because the bus cannot be stalled from the read side, so the consumer must accept every word in the cycle its strobe is high. On the write stream a word is transferred in a cycle where both `wr_valid` and `wr_ready` are high. The producer may hold `wr_valid` low for as long as it needs, and the burst waits for it.

The address phase and the data phase are tracked by separate state. An error on the final beat is therefore still caught in the cycles after the bus has returned to IDLE, and it is charged to that beat. A configuration bit is latched with each command and selects what happens on an error. In abort mode the beats not yet issued are cancelled during the first cycle of the two-cycle error response. In continue mode the burst goes on once that response ends. When the last outstanding data phase has finished, the block pulses `done`. At the same time it presents an error flag and the index of the first beat that failed.

Top module: `ahb_burst_master`

## Requirements
- R1: `cmd_ready` is high whenever no burst is active, including right after reset. A command is accepted on a cycle with `cmd_valid` and `cmd_ready` both high, and `cfg_abort` is sampled on that same cycle.
- R2: HTRANS is driven NONSEQ (2'b10) for the first beat and SEQ (2'b11) for every later beat. It is IDLE (2'b00) when no beat is requested. It is BUSY (2'b01) when a write burst is waiting for stream data after its first beat. HBURST is always 3'b001 (incrementing, undefined length) and HSIZE is always 3'b010 (one 32-bit word).
- R3: Beat k of a burst is issued at address base + 4*k.
- R4: While HREADY is low, HADDR, HTRANS and HWRITE hold their values. The single exception is the cancellation of R8.
- R5: The k-th word accepted from the write stream is driven on HWDATA during the data phase of write beat k, and it is held there while HREADY is low.
- R6: For every read beat that completes with HREADY high and HRESP OKAY (0), `rd_valid` is high for one cycle with `rd_data` equal to HRDATA. The words arrive in beat order, and a beat that ends in ERROR produces no word.
- R7: HRESP is examined in the data phase of every beat, whatever HTRANS shows at that moment. A transfer counts as finished only on a cycle with HREADY high, so an ERROR on the last beat is reported even though HTRANS is already IDLE.
- R8: In abort mode, on the first error cycle (HRESP ERROR with HREADY low) HTRANS becomes IDLE on the next cycle. No beat after the failed one reaches a data phase.
- R9: In continue mode, after an error has completed, every remaining beat of the burst is still issued.
- R10: `done` pulses for one cycle, on the cycle after the last data phase completes. `err_flag` (1 means some beat failed) and `err_beat` (the 0-based index of the first failed beat) are valid from that pulse until the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle, command accepted |
| cmd_addr | input | AW | Base address of the burst |
| cmd_len | input | LW | Number of beats |
| cmd_write | input | 1 | 1 for a write burst, 0 for a read burst |
| cfg_abort | input | 1 | 1 cancels the rest of the burst on error |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Write word taken |
| wr_data | input | DW | Write word |
| rd_valid | output | 1 | Read word strobe |
| rd_data | output | DW | Read word |
| done | output | 1 | Burst finished pulse |
| err_flag | output | 1 | Some beat of the last burst failed |
| err_beat | output | LW | Index of the first failed beat |
| haddr | output | AW | Bus address |
| htrans | output | 2 | Transfer type |
| hburst | output | 3 | Burst type |
| hsize | output | 3 | Transfer size |
| hwrite | output | 1 | Transfer direction |
| hwdata | output | DW | Bus write data |
| hrdata | input | DW | Bus read data |
| hready | input | 1 | Transfer completion from the slave |
| hresp | input | 1 | Slave response, 1 is ERROR |

## Verification
Several properties are checked on every cycle. The address-phase outputs and HWDATA must stay frozen during wait states. A SEQ beat must always follow an accepted NONSEQ and sit 4 bytes above the previous accepted beat. HTRANS must go to IDLE right after a first error cycle in abort mode. The bus must be quiet whenever `done` is high.

Other behaviour can only be shown by the bench's slave model and scoreboard. That covers:
- which stream word lands on which beat;
- the order of read words, and the gaps left by failed beats;
- how many beats reach a data phase under abort and under continue;
- the exact cycle of `done`;
- the reported beat index when the error falls on the final beat after HTRANS has gone IDLE.

// File: rtl/ahbm_pkg.sv
package ahbm_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } htrans_e;

  localparam logic [2:0] BURST_INCR = 3'b001;
  localparam logic [2:0] SIZE_WORD  = 3'b010;
endpackage

// File: rtl/ahbm_addr_phase.sv
module ahbm_addr_phase
  import ahbm_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hready,
  input  logic          busy,
  input  logic          start,
  input  logic [AW-1:0] base_in,
  input  logic [LW-1:0] len_in,
  input  logic          wr_in,
  input  logic          abort_en,
  input  logic          err_first,
  input  logic          err_end,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic [1:0]    htrans,
  output logic [AW-1:0] haddr,
  output logic          hwrite,
  output logic          aph_valid,
  output logic [LW-1:0] aph_idx,
  output logic [DW-1:0] aph_wdata,
  output logic          wr_ready,
  output logic          issue_over
);
  htrans_e       htrans_q;
  logic [LW-1:0] nxt;
  logic [LW-1:0] len_q;
  logic [AW-1:0] base_q;
  logic          stopped;
  logic          stop_now;
  logic          more;
  logic          issue;

  // an error completing this cycle stops issue at once in abort mode
  assign stop_now   = stopped | (abort_en & err_end);
  assign more       = busy & (nxt != len_q) & ~stop_now;
  assign issue      = more & (~hwrite | wr_valid);
  assign wr_ready   = hready & more & hwrite;
  assign issue_over = ~busy | (nxt == len_q) | stop_now;
  assign htrans     = htrans_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      htrans_q  <= TR_IDLE;
      nxt       <= '0;
      len_q     <= '0;
      base_q    <= '0;
      haddr     <= '0;
      hwrite    <= 1'b0;
      stopped   <= 1'b0;
      aph_valid <= 1'b0;
      aph_idx   <= '0;
      aph_wdata <= '0;
    end else if (start) begin
      nxt       <= '0;
      len_q     <= len_in;
      base_q    <= base_in;
      hwrite    <= wr_in;
      stopped   <= 1'b0;
      aph_valid <= 1'b0;
      htrans_q  <= TR_IDLE;
    end else if (hready) begin
      stopped <= stop_now;
      if (issue) begin
        aph_valid <= 1'b1;
        aph_idx   <= nxt;
        aph_wdata <= wr_data;
        haddr     <= base_q + (AW'(nxt) << 2);
        htrans_q  <= (nxt == '0) ? TR_NONSEQ : TR_SEQ;
        nxt       <= nxt + 1'b1;
      end else begin
        aph_valid <= 1'b0;
        htrans_q  <= (more && nxt != '0) ? TR_BUSY : TR_IDLE;
      end
    end else if (err_first && abort_en) begin
      // first cycle of a two-cycle error: drop the pending beat
      stopped   <= 1'b1;
      aph_valid <= 1'b0;
      htrans_q  <= TR_IDLE;
    end
  end
endmodule

// File: rtl/ahbm_data_phase.sv
module ahbm_data_phase #(
  parameter int DW = 32,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hready,
  input  logic          hresp,
  input  logic [DW-1:0] hrdata,
  input  logic          start,
  input  logic          aph_valid,
  input  logic [LW-1:0] aph_idx,
  input  logic          aph_wr,
  input  logic [DW-1:0] aph_wdata,
  output logic [DW-1:0] hwdata,
  output logic          dp_pend,
  output logic          err_first,
  output logic          err_end,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          err_any,
  output logic [LW-1:0] err_which
);
  logic [LW-1:0] dp_idx;
  logic          dp_wr;
  logic          err_seen;
  logic [LW-1:0] err_idx;

  // the data phase is judged by its own pending flag, not by htrans
  assign err_first = dp_pend & hresp & ~hready;
  assign err_end   = dp_pend & hresp & hready;
  assign rd_valid  = dp_pend & hready & ~hresp & ~dp_wr;
  assign rd_data   = hrdata;
  assign err_any   = err_seen | err_end;
  assign err_which = err_seen ? err_idx : dp_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_pend <= 1'b0;
      dp_idx  <= '0;
      dp_wr   <= 1'b0;
      hwdata  <= '0;
    end else if (hready) begin
      dp_pend <= aph_valid;
      if (aph_valid) begin
        dp_idx <= aph_idx;
        dp_wr  <= aph_wr;
        if (aph_wr) hwdata <= aph_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_seen <= 1'b0;
      err_idx  <= '0;
    end else if (start) begin
      err_seen <= 1'b0;
    end else if (err_end && !err_seen) begin
      err_seen <= 1'b1;
      err_idx  <= dp_idx;
    end
  end
endmodule

// File: rtl/ahb_burst_master.sv
module ahb_burst_master
  import ahbm_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_addr,
  input  logic [LW-1:0] cmd_len,
  input  logic          cmd_write,
  input  logic          cfg_abort,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          done,
  output logic          err_flag,
  output logic [LW-1:0] err_beat,
  output logic [AW-1:0] haddr,
  output logic [1:0]    htrans,
  output logic [2:0]    hburst,
  output logic [2:0]    hsize,
  output logic          hwrite,
  output logic [DW-1:0] hwdata,
  input  logic [DW-1:0] hrdata,
  input  logic          hready,
  input  logic          hresp
);
  logic          busy;
  logic          abort_q;
  logic          start;
  logic          fin;
  logic          aph_valid;
  logic [LW-1:0] aph_idx;
  logic [DW-1:0] aph_wdata;
  logic          issue_over;
  logic          dp_pend;
  logic          err_first;
  logic          err_end;
  logic          err_any;
  logic [LW-1:0] err_which;

  assign cmd_ready = ~busy;
  assign start     = cmd_valid & ~busy;
  assign hburst    = BURST_INCR;
  assign hsize     = SIZE_WORD;
  // last data phase completes this edge and nothing more will be issued
  assign fin       = busy & hready & ~aph_valid & issue_over;

  ahbm_addr_phase #(.AW(AW), .DW(DW), .LW(LW)) u_aph (
    .clk(clk), .rst_n(rst_n), .hready(hready), .busy(busy), .start(start),
    .base_in(cmd_addr), .len_in(cmd_len), .wr_in(cmd_write), .abort_en(abort_q),
    .err_first(err_first), .err_end(err_end), .wr_valid(wr_valid), .wr_data(wr_data),
    .htrans(htrans), .haddr(haddr), .hwrite(hwrite), .aph_valid(aph_valid),
    .aph_idx(aph_idx), .aph_wdata(aph_wdata), .wr_ready(wr_ready),
    .issue_over(issue_over)
  );

  ahbm_data_phase #(.DW(DW), .LW(LW)) u_dph (
    .clk(clk), .rst_n(rst_n), .hready(hready), .hresp(hresp), .hrdata(hrdata),
    .start(start), .aph_valid(aph_valid), .aph_idx(aph_idx), .aph_wr(hwrite),
    .aph_wdata(aph_wdata), .hwdata(hwdata), .dp_pend(dp_pend),
    .err_first(err_first), .err_end(err_end), .rd_valid(rd_valid),
    .rd_data(rd_data), .err_any(err_any), .err_which(err_which)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      abort_q  <= 1'b0;
      done     <= 1'b0;
      err_flag <= 1'b0;
      err_beat <= '0;
    end else begin
      done <= fin;
      if (start) begin
        busy     <= 1'b1;
        abort_q  <= cfg_abort;
        err_flag <= 1'b0;
        err_beat <= '0;
      end else if (fin) begin
        busy     <= 1'b0;
        err_flag <= err_any;
        err_beat <= err_which;
      end
    end
  end
endmodule

// File: rtl/ahbm_chk.sv
module ahbm_chk
  import ahbm_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hready,
  input logic          hresp,
  input logic [1:0]    htrans,
  input logic [AW-1:0] haddr,
  input logic          hwrite,
  input logic [DW-1:0] hwdata,
  input logic          dp_pend,
  input logic          abort_q,
  input logic          done
);
  logic          past_ok;
  logic          have_acc;
  logic [AW-1:0] last_acc;
  logic          acc_now;

  assign acc_now = hready && (htrans == TR_NONSEQ || htrans == TR_SEQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok  <= 1'b0;
      have_acc <= 1'b0;
      last_acc <= '0;
    end else begin
      past_ok <= 1'b1;
      if (acc_now) begin
        have_acc <= 1'b1;
        last_acc <= haddr;
      end else if (done) begin
        have_acc <= 1'b0;
      end
    end
  end

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(hready) && !$past(hresp && dp_pend && abort_q))
      |-> ($stable(htrans) && $stable(haddr) && $stable(hwrite)));

  // R5
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(hready) && $past(dp_pend) && dp_pend) |-> $stable(hwdata));

  // R8
  abort_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_pend && hresp && !hready && abort_q) |=> (htrans == TR_IDLE));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hready && htrans == TR_SEQ && have_acc) |-> (haddr == last_acc + AW'(4)));

  // R2
  seq_after_nonseq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == TR_SEQ) |-> have_acc);

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (htrans == TR_IDLE && !dp_pend));
endmodule

bind ahb_burst_master ahbm_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hready(hready), .hresp(hresp), .htrans(htrans),
  .haddr(haddr), .hwrite(hwrite), .hwdata(hwdata), .dp_pend(dp_pend),
  .abort_q(abort_q), .done(done)
);

// File: tb/ahb_burst_master_tb.sv
module ahb_burst_master_tb;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int LW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic [LW-1:0] cmd_len = '0;
  logic          cmd_write = 1'b0;
  logic          cfg_abort = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [DW-1:0] wr_data = '0;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          done;
  logic          err_flag;
  logic [LW-1:0] err_beat;
  logic [AW-1:0] haddr;
  logic [1:0]    htrans;
  logic [2:0]    hburst;
  logic [2:0]    hsize;
  logic          hwrite;
  logic [DW-1:0] hwdata;
  logic [DW-1:0] hrdata = '0;
  logic          hready = 1'b1;
  logic          hresp = 1'b0;

  ahb_burst_master #(.AW(AW), .DW(DW), .LW(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_write(cmd_write),
    .cfg_abort(cfg_abort), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
    .err_flag(err_flag), .err_beat(err_beat), .haddr(haddr), .htrans(htrans),
    .hburst(hburst), .hsize(hsize), .hwrite(hwrite), .hwdata(hwdata),
    .hrdata(hrdata), .hready(hready), .hresp(hresp)
  );

  always #5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  // scenario, set by the driver
  int          scen_id = 0;
  int          scen_len = 0;
  bit          scen_wr = 1'b0;
  bit          scen_abort = 1'b0;
  bit          scen_gap = 1'b0;
  logic [31:0] scen_base = '0;
  logic [31:0] wmask = '0;
  logic [31:0] emask = '0;

  // slave model state
  int          cyc = 0;
  int          acc_cnt = 0;
  int          wsent = 0;
  int          busy_seen = 0;
  int          last_cmp = -10;
  bit          dp_act = 1'b0;
  int          dp_idx = 0;
  logic [31:0] dp_addr = '0;
  bit          dp_wr = 1'b0;
  int          wleft = 0;
  bit          ephase = 1'b0;
  bit          took_wr = 1'b0;
  bit          prev_ok = 1'b0;
  bit          prev_hready = 1'b1;
  bit          prev_cancel = 1'b0;
  logic [1:0]  prev_htrans = '0;
  logic [31:0] prev_haddr = '0;
  logic [1:0]  last_err_tr = 2'b11;
  logic [31:0] rdq[$];

  function automatic logic [31:0] rpat(input logic [31:0] a);
    return a ^ 32'hA5A5_0000;
  endfunction

  function automatic logic [31:0] wpat(input int i);
    return 32'hC0DE_0000 + 32'(scen_id << 8) + 32'(i);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model, write-data source and read monitor
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      hready = 1'b1; hresp = 1'b0; wr_valid = 1'b0;
      dp_act = 1'b0; prev_ok = 1'b0; took_wr = 1'b0;
    end else begin
      if (took_wr) wsent++;
      if (cmd_valid && cmd_ready) begin
        acc_cnt = 0; wsent = 0; busy_seen = 0; dp_act = 0;
        ephase = 0; took_wr = 0; last_err_tr = 2'b11;
      end
      if (prev_ok && !prev_hready && !prev_cancel)
        chk(htrans == prev_htrans && haddr == prev_haddr, "R4 hold in wait",
            haddr, prev_haddr);
      hresp = 1'b0;
      if (dp_act) begin
        if (emask[dp_idx] && !ephase) begin
          hready = 1'b0; hresp = 1'b1; ephase = 1'b1;
          if (dp_idx == scen_len - 1) last_err_tr = htrans;
        end else if (ephase) begin
          hready = 1'b1; hresp = 1'b1; ephase = 1'b0;
        end else if (wleft > 0) begin
          hready = 1'b0; wleft--;
        end else begin
          hready = 1'b1;
          if (dp_wr) chk(hwdata == wpat(dp_idx), "R5 write data", hwdata, wpat(dp_idx));
          else hrdata = rpat(dp_addr);
        end
      end else begin
        hready = 1'b1;
      end
      prev_cancel = dp_act && hresp && !hready && scen_abort;
      if (hready) begin
        if (dp_act) last_cmp = cyc;
        if (htrans == 2'b10 || htrans == 2'b11) begin
          chk(htrans == ((acc_cnt == 0) ? 2'b10 : 2'b11), "R2 transfer type",
              32'(htrans), 32'((acc_cnt == 0) ? 2 : 3));
          chk(haddr == scen_base + 32'(4 * acc_cnt), "R3 address", haddr,
              scen_base + 32'(4 * acc_cnt));
          chk(hburst == 3'b001 && hsize == 3'b010 && hwrite == scen_wr,
              "R2 burst/size/dir", {hburst, hsize, hwrite}, {3'b001, 3'b010, scen_wr});
          dp_act = 1'b1; dp_idx = acc_cnt; dp_addr = haddr; dp_wr = hwrite;
          wleft = wmask[acc_cnt] ? 2 : 0; ephase = 1'b0;
          acc_cnt++;
        end else begin
          if (htrans == 2'b01) busy_seen++;
          dp_act = 1'b0;
        end
      end
      prev_ok = 1'b1; prev_hready = hready; prev_htrans = htrans; prev_haddr = haddr;
      wr_valid = scen_wr && (wsent < scen_len) && (!scen_gap || (cyc % 3 != 0));
      wr_data = wpat(wsent);
      #2;
      took_wr = wr_valid && wr_ready;
      if (rd_valid) begin
        if (rdq.size() == 0) chk(1'b0, "R6 unexpected read word", rd_data, 0);
        else begin
          logic [31:0] e;
          e = rdq.pop_front();
          chk(rd_data == e, "R6 read word", rd_data, e);
        end
      end
    end
  end

  task automatic run_burst(input int id, input logic [31:0] base, input int len,
                           input bit wr, input bit ab, input bit gap,
                           input logic [31:0] wm, input logic [31:0] em,
                           input bit xerr, input int xbeat, input int xdps);
    int n;
    @(posedge clk); #2;
    scen_id = id; scen_base = base; scen_len = len; scen_wr = wr;
    scen_abort = ab; scen_gap = gap; wmask = wm; emask = em;
    if (!wr)
      for (int i = 0; i < xdps; i++)
        if (!em[i]) rdq.push_back(rpat(base + 32'(4 * i)));
    chk(cmd_ready == 1'b1, "R1 ready before command", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_addr = base; cmd_len = LW'(len);
    cmd_write = wr; cfg_abort = ab;
    @(posedge clk); #2;
    cmd_valid = 1'b0; cfg_abort = ~ab;
    n = 0;
    do begin @(negedge clk); #3; n++; end while (!done && n < 2000);
    chk(done == 1'b1, "R10 done seen", done, 1);
    chk(cyc == last_cmp + 1, "R10 done one cycle after last data phase",
        32'(cyc), 32'(last_cmp + 1));
    chk(err_flag == xerr, "R7 error flag", err_flag, xerr);
    if (xerr) chk(err_beat == LW'(xbeat), "R7 failed beat index", err_beat, xbeat);
    chk(acc_cnt == xdps, ab ? "R8 beats reaching data phase" : "R9 beats reaching data phase",
        acc_cnt, xdps);
    chk(rdq.size() == 0, "R6 all read words delivered", rdq.size(), 0);
    if (em[len-1]) chk(last_err_tr == 2'b00, "R7 last-beat error while htrans idle",
                       last_err_tr, 0);
    if (gap) chk(busy_seen > 0, "R2 busy while waiting for write data", busy_seen, 1);
    @(negedge clk); #3;
    chk(done == 1'b0 && cmd_ready == 1'b1, "R10 single pulse / R1 ready again",
        {done, cmd_ready}, 2'b01);
    rdq.delete();
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk); #3;
    chk(htrans == 2'b00, "R2 idle after reset", htrans, 0);
    chk(cmd_ready == 1'b1, "R1 ready after reset", cmd_ready, 1);
    chk(done == 1'b0 && err_flag == 1'b0, "R10 no status after reset", {done, err_flag}, 0);
    // id, base, len, wr, abort, gap, waitmask, errmask, xerr, xbeat, xdps
    run_burst(1, 32'h100, 4, 1, 0, 0, 32'h0,  32'h0,  0, 0, 4);
    run_burst(2, 32'h200, 5, 0, 0, 0, 32'h0A, 32'h0,  0, 0, 5);
    run_burst(3, 32'h300, 6, 1, 0, 1, 32'h04, 32'h0,  0, 0, 6);
    run_burst(4, 32'h400, 4, 0, 1, 0, 32'h0,  32'h08, 1, 3, 4);
    run_burst(5, 32'h500, 6, 0, 1, 0, 32'h0,  32'h04, 1, 2, 3);
    run_burst(6, 32'h600, 6, 0, 0, 0, 32'h0,  32'h04, 1, 2, 6);
    run_burst(7, 32'h700, 5, 1, 0, 0, 32'h01, 32'h0A, 1, 1, 5);
    run_burst(8, 32'h800, 1, 1, 1, 0, 32'h0,  32'h01, 1, 0, 1);
    run_burst(9, 32'h900, 5, 1, 1, 1, 32'h02, 32'h04, 1, 2, 3);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule